// File: doc/BRIEF.md
# Index/Data Global Configuration Register Bank

This block holds the chip-wide configuration registers that a host reaches through two byte-wide ports. The host first writes an 8-bit register number to the index port. It then reads or writes the chosen register through the data port. Both ports respond only while the `cfg_mode` input is high. At all other times, writes are dropped and reads return zero. Entering and leaving configuration mode is handled elsewhere and arrives here as a plain level.

Three locations are implemented:

- **Control register (index 0x02).** Writing 1 to bit 0 sends a one-cycle soft-reset pulse to the rest of the chip. The bit is never stored, so it clears itself.
- **Run-mode access register (index 0x03).** Bit 7 opens access to the general-purpose, watchdog-control and power-control register group while the chip is outside configuration mode. Bits [1:0] choose which of four run-mode base addresses that group answers at.
- **Device-select register (index 0x07).** This 8-bit register names the logical device that device-level commands act on.

The full 8-bit index is decoded, so no location is an alias of another. Every other index reads as zero and ignores writes.

Top module: `gcfg_bank`

## Requirements
- R1: After a synchronous reset, the outputs and registers hold these values: index register 0x00, device number 0x00, run access disabled, run-mode base 0xEA, no soft-reset pulse, and register 0x03 reads 0x03.
- R2: While `cfg_mode` is high, a write through the index port (`port_sel`=0) loads the 8-bit index register. A read through the index port returns the index register's value.
- R3: A configuration-mode data write to index 0x02 with bit 0 = 1 raises `soft_rst` for exactly the one cycle after the write. A write with bit 0 = 0 gives no pulse. Reads of index 0x02 return 0x00.
- R4: Bit 7 of register 0x03 drives `run_access_en`. Bits [6:2] of register 0x03 ignore writes and read as 0.
- R5: Bits [1:0] of register 0x03 choose the run-mode base address: 2'b11 gives 0xEA, 2'b10 gives 0xE4, 2'b01 gives 0xE2 and 2'b00 gives 0xE0.
- R6: Register 0x07 is read/write over all 8 bits, and its value appears on `ldev_num`.
- R7: Any index other than 0x02, 0x03 and 0x07 reads as 0x00, and a write to it changes no output and no register. This covers indices whose low bits match an implemented register, such as 0x83 or 0x47.
- R8: While `cfg_mode` is low, writes on both ports are ignored and reads on both ports return 0x00.
- R9: A soft-reset pulse does not clear the index register, register 0x03 or register 0x07.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 1 | High while the chip is in configuration mode |
| port_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; `rdata` is valid in the same cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data from the selected port |
| soft_rst | output | 1 | One-cycle soft-reset pulse |
| ldev_num | output | 8 | Currently selected logical device |
| run_access_en | output | 1 | Run-mode access to the general-purpose group is enabled |
| run_base | output | 8 | Run-mode base address of the general-purpose group |

## Verification
The assertions check four properties on every cycle:

- no output register moves while `cfg_mode` is low, and no read returns anything but zero then;
- the reserved bits of register 0x03 never read as 1, and `run_base` only ever holds one of the four legal addresses;
- the index register changes only on an index-port write;
- every soft-reset pulse follows a qualifying write to index 0x02.

Only the bench scenarios can show the rest:

- the exact mapping from each 2-bit code to its base address;
- the exact width and timing of the pulse;
- that aliased indices such as 0x83 are rejected;
- that register contents survive a soft reset.

// File: rtl/gcfg_pkg.sv
package gcfg_pkg;
    localparam int DW = 8;
    localparam int SELW = 2;

    typedef logic [DW-1:0] byte_t;

    localparam byte_t IDX_CTL = 8'h02;
    localparam byte_t IDX_ACC = 8'h03;
    localparam byte_t IDX_LDN = 8'h07;

    localparam logic [SELW-1:0] SEL_RESET = 2'b11;
    localparam int SOFT_BIT = 0;
    localparam int RUN_BIT = DW - 1;

    typedef struct packed {
        logic ctl;
        logic acc;
        logic ldn;
    } hit_t;

    typedef struct packed {
        logic            run_en;
        logic [SELW-1:0] base_sel;
    } acc_t;

    function automatic byte_t base_of(logic [SELW-1:0] s);
        case (s)
            2'b11:   return 8'hEA;
            2'b10:   return 8'hE4;
            2'b01:   return 8'hE2;
            default: return 8'hE0;
        endcase
    endfunction

    function automatic byte_t acc_view(acc_t a);
        byte_t v;
        v = '0;
        v[RUN_BIT] = a.run_en;
        v[SELW-1:0] = a.base_sel;
        return v;
    endfunction
endpackage

// File: rtl/gcfg_index_reg.sv
module gcfg_index_reg
    import gcfg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr,
    input  byte_t wdata,
    output byte_t index_q
);
    always_ff @(posedge clk) begin
        if (rst) index_q <= '0;
        else if (wr) index_q <= wdata;
    end

    assert_idx_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(index_q));
endmodule

// File: rtl/gcfg_decode.sv
module gcfg_decode
    import gcfg_pkg::*;
(
    input  byte_t index_q,
    output hit_t  hit
);
    always_comb begin
        hit.ctl = (index_q == IDX_CTL);
        hit.acc = (index_q == IDX_ACC);
        hit.ldn = (index_q == IDX_LDN);
    end
endmodule

// File: rtl/gcfg_regs.sv
module gcfg_regs
    import gcfg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr,
    input  hit_t  hit,
    input  byte_t wdata,
    output logic  soft_rst,
    output acc_t  acc_q,
    output byte_t ldn_q,
    output byte_t run_base
);
    always_ff @(posedge clk) begin
        if (rst) begin
            soft_rst <= 1'b0;
            acc_q.run_en <= 1'b0;
            acc_q.base_sel <= SEL_RESET;
            ldn_q <= '0;
        end else begin
            soft_rst <= wr && hit.ctl && wdata[SOFT_BIT];
            if (wr && hit.acc) begin
                acc_q.run_en <= wdata[RUN_BIT];
                acc_q.base_sel <= wdata[SELW-1:0];
            end
            if (wr && hit.ldn) ldn_q <= wdata;
        end
    end

    always_comb run_base = base_of(acc_q.base_sel);

    assert_base_legal_R5: assert property (@(posedge clk) disable iff (rst)
        (run_base == 8'hEA) || (run_base == 8'hE4) ||
        (run_base == 8'hE2) || (run_base == 8'hE0));
endmodule

// File: rtl/gcfg_bank.sv
module gcfg_bank
    import gcfg_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_mode,
    input  logic         port_sel,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic [7:0]   wdata,
    output logic [7:0]   rdata,
    output logic         soft_rst,
    output logic [7:0]   ldev_num,
    output logic         run_access_en,
    output logic [7:0]   run_base
);
    byte_t index_q;
    byte_t ldn_q;
    byte_t data_view;
    hit_t  hit;
    acc_t  acc_q;
    logic  idx_wr;
    logic  dat_wr;

    always_comb begin
        idx_wr = cfg_mode && wr_en && !port_sel;
        dat_wr = cfg_mode && wr_en && port_sel;
    end

    gcfg_index_reg u_index (
        .clk(clk), .rst(rst), .wr(idx_wr), .wdata(wdata), .index_q(index_q)
    );

    gcfg_decode u_decode (
        .index_q(index_q), .hit(hit)
    );

    gcfg_regs u_regs (
        .clk(clk), .rst(rst), .wr(dat_wr), .hit(hit), .wdata(wdata),
        .soft_rst(soft_rst), .acc_q(acc_q), .ldn_q(ldn_q), .run_base(run_base)
    );

    always_comb begin
        data_view = '0;
        if (hit.acc) data_view = acc_view(acc_q);
        if (hit.ldn) data_view = ldn_q;
        if (!cfg_mode || !rd_en) rdata = '0;
        else if (port_sel) rdata = data_view;
        else rdata = index_q;
    end

    assign ldev_num = ldn_q;
    assign run_access_en = acc_q.run_en;

    assert_nocfg_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !cfg_mode |-> rdata == 8'h00);

    assert_nocfg_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !cfg_mode |=> $stable(ldev_num) && $stable(run_access_en) && $stable(run_base));

    assert_rsvd_bits_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && port_sel && index_q == IDX_ACC) |-> rdata[6:2] == 5'b0);

    assert_pulse_cause_R3: assert property (@(posedge clk) disable iff (rst)
        soft_rst |-> $past(cfg_mode && wr_en && port_sel && index_q == IDX_CTL && wdata[0]));
endmodule

// File: tb/gcfg_bank_test.sv
module gcfg_bank_test;
    logic       clk = 0;
    logic       rst = 1;
    logic       cfg_mode = 0, port_sel = 0, wr_en = 0, rd_en = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata, ldev_num, run_base;
    logic       soft_rst, run_access_en;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    gcfg_bank uut (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .port_sel(port_sel),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .soft_rst(soft_rst), .ldev_num(ldev_num), .run_access_en(run_access_en),
        .run_base(run_base)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data at the sampling point of each read cycle
    always @(negedge clk) begin
        if (rd_en) begin
            if (exp_q.size() == 0) chk("SCOREBOARD", 8'hFF, 8'h00);
            else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
        end
    end

    task automatic wr(input logic sel, input logic [7:0] d);
        @(posedge clk); #1;
        port_sel = sel; wdata = d; wr_en = 1;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic rd(input logic sel, input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        port_sel = sel; rd_en = 1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(posedge clk); #1;
        rd_en = 0;
    endtask

    task automatic outs(input string tag, input logic [7:0] ldn, input logic en,
                        input logic [7:0] base);
        @(negedge clk);
        chk({tag, " ldev"}, ldev_num, ldn);
        chk({tag, " run_en"}, {7'b0, run_access_en}, {7'b0, en});
        chk({tag, " base"}, run_base, base);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 pulse", {7'b0, soft_rst}, 8'h00);
        outs("R1", 8'h00, 1'b0, 8'hEA);
        cfg_mode = 1;
        rd(0, 8'h00, "R1 index");
        wr(0, 8'h03);
        rd(1, 8'h03, "R1 reg03");

        // R2 index port
        wr(0, 8'h5A);
        rd(0, 8'h5A, "R2 index readback");

        // R4/R5 access register
        wr(0, 8'h03);
        wr(1, 8'hFE);
        rd(1, 8'h82, "R4 reserved bits");
        outs("R4 R5 sel10", 8'h00, 1'b1, 8'hE4);
        wr(1, 8'h01);
        outs("R5 sel01", 8'h00, 1'b0, 8'hE2);
        wr(1, 8'h00);
        outs("R5 sel00", 8'h00, 1'b0, 8'hE0);
        wr(1, 8'h83);
        outs("R5 sel11", 8'h00, 1'b1, 8'hEA);

        // R6 device select
        wr(0, 8'h07);
        wr(1, 8'hA5);
        rd(1, 8'hA5, "R6 readback");
        outs("R6", 8'hA5, 1'b1, 8'hEA);

        // R3 soft reset pulse
        wr(0, 8'h02);
        wr(1, 8'h00);
        @(negedge clk);
        chk("R3 no pulse on 0", {7'b0, soft_rst}, 8'h00);
        @(posedge clk); #1;
        port_sel = 1; wdata = 8'h01; wr_en = 1;
        @(posedge clk); #1;
        wr_en = 0;
        @(negedge clk);
        chk("R3 pulse high", {7'b0, soft_rst}, 8'h01);
        @(negedge clk);
        chk("R3 pulse one cycle", {7'b0, soft_rst}, 8'h00);
        rd(1, 8'h00, "R3 read 0x02");

        // R9 registers survive soft reset
        rd(0, 8'h02, "R9 index kept");
        outs("R9", 8'hA5, 1'b1, 8'hEA);

        // R7 unimplemented and aliased indices
        for (int k = 0; k < 4; k++) begin
            logic [7:0] ix;
            ix = (k == 0) ? 8'h83 : (k == 1) ? 8'h47 : (k == 2) ? 8'h00 : 8'h2F;
            wr(0, ix);
            wr(1, 8'h40);
            rd(1, 8'h00, "R7 unimplemented read");
            outs("R7 no effect", 8'hA5, 1'b1, 8'hEA);
        end

        // R8 outside configuration mode
        wr(0, 8'h07);
        cfg_mode = 0;
        wr(1, 8'h11);
        wr(0, 8'h03);
        rd(1, 8'h00, "R8 data read zero");
        rd(0, 8'h00, "R8 index read zero");
        outs("R8 no write", 8'hA5, 1'b1, 8'hEA);
        cfg_mode = 1;
        rd(0, 8'h07, "R8 index unchanged");
        rd(1, 8'hA5, "R8 ldn unchanged");

        @(negedge clk);
        if (exp_q.size() != 0) chk("SCOREBOARD drain", 8'(exp_q.size()), 8'h00);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL WATCHDOG: actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule